// File: doc/BRIEF.md
# Two-Stage Lookup Logic Cell

This block is a behavioural model of one programmable logic cell. Two 4-input lookup tables form the first stage. Their outputs, together with one extra input, address a 3-input table in the second stage. Two storage flops take their data either from the tables or from a direct data input. Each of the two outputs can show either its flop or its combinational value.

A single configuration word holds every table bit and every selector. It is written in parallel while a load strobe is high. While the strobe is high the flops are cleared. The cell passes its outputs through only once loading has finished.

A small controller sequences the cell through three named states:
- **ST_BLANK** is the state after reset, with nothing loaded.
- **ST_LOAD** is the state while the configuration is being written.
- **ST_RUN** is normal operation.

The named transitions are:
- **BLANK→LOAD** on a strobe.
- **LOAD→LOAD** while the strobe stays high.
- **LOAD→RUN** at the first edge with the strobe low.
- **RUN→LOAD** on any later strobe.

One cell can produce two unrelated 4-input functions. With the second table set up as a selector, it can instead produce any single function of five inputs.

Top module: `clb_two_stage`

## Requirements
- R1: A rising clock edge with `rst_n` low clears the configuration, both flops and the controller, which goes to ST_BLANK. Both outputs are 0 from then until configuration completes.
- R2: A rising edge with `cfg_we` high stores `cfg_word` (44 bits). The field positions are:
  - bits 43:28: table F.
  - bits 27:12: table G.
  - bits 11:4: table H.
  - bit 3: flop A source.
  - bit 2: flop B source.
  - bit 1: output A registered.
  - bit 0: output B registered.
- R3: The controller moves ST_BLANK→ST_LOAD and ST_RUN→ST_LOAD on an edge with `cfg_we` high. It stays in ST_LOAD while `cfg_we` is high and moves ST_LOAD→ST_RUN on the first edge with `cfg_we` low. Both outputs are 0 in any state other than ST_RUN.
- R4: The first-stage value F is bit `f_in` of table F, and G is bit `g_in` of table G, each input group taken as an unsigned index.
- R5: The second-stage value H is bit {`h_in`,G,F} of table H (`h_in` is the index MSB, F the LSB).
- R6: In ST_RUN, with its registered bit 0, `out_a` equals H and `out_b` equals G combinationally. Setting table H to 8'hAA therefore gives two independent 4-input functions.
- R7: With table H = 8'hCA, `out_a` equals G when `h_in` is 1 and F when it is 0. Loading the two halves of a 32-entry truth table into F and G, with both groups driven by the same four inputs, realises any 5-input function.
- R8: A source bit of 0 feeds flop A from H and flop B from G. A source bit of 1 feeds the flop from `d_in`.
- R9: The flops capture on rising edges where the controller is in ST_RUN and `cfg_we` is low. With its registered bit 1, an output shows its flop.
- R10: Every edge with `cfg_we` high clears both flops. The registered outputs read 0 after loading until the first capture in ST_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_word | input | 44 | Configuration word (layout in R2) |
| f_in | input | 4 | Index inputs of table F |
| g_in | input | 4 | Index inputs of table G |
| h_in | input | 1 | Extra second-stage input |
| d_in | input | 1 | Direct data input to the flops |
| out_a | output | 1 | Output A (H path) |
| out_b | output | 1 | Output B (G path) |

## Verification
The assertions take all inputs as synchronous, stable around each rising edge, and never X after reset. They also assume that `cfg_word` is meaningful only on edges where `cfg_we` is high. The stimulus respects this by driving every input on the falling edge. Random configurations and random logic inputs are drawn from a fixed seed. Reloads and resets occur only as whole-cycle strobes, so the register-bypass checks always refer to a configuration that stays constant across the checked edge.

// File: rtl/clb_pkg.sv
package clb_pkg;
    localparam int FIRST_K  = 4;
    localparam int SECOND_K = 3;
    localparam int FIRST_W  = 1 << FIRST_K;
    localparam int SECOND_W = 1 << SECOND_K;
    localparam int N_FF     = 2;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2
    } clb_state_e;

    typedef struct packed {
        logic [FIRST_W-1:0]  tab_f;
        logic [FIRST_W-1:0]  tab_g;
        logic [SECOND_W-1:0] tab_h;
        logic                src_a;
        logic                src_b;
        logic                reg_a;
        logic                reg_b;
    } clb_cfg_t;

    localparam int CFG_W = $bits(clb_cfg_t);
endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
    parameter int K = 4,
    localparam int W = 1 << K
) (
    input  logic [W-1:0] table_bits,
    input  logic [K-1:0] sel,
    output logic         y
);
    always_comb begin
        y = table_bits[sel];
    end
endmodule

// File: rtl/clb_cfg_ctrl.sv
module clb_cfg_ctrl
    import clb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_word,
    output clb_cfg_t             cfg,
    output logic                 running,
    output logic                 capture
);
    clb_state_e state_q, state_d;
    clb_cfg_t   cfg_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: if (cfg_we)  state_d = ST_LOAD;
            ST_LOAD:  if (!cfg_we) state_d = ST_RUN;
            ST_RUN:   if (cfg_we)  state_d = ST_LOAD;
            default:               state_d = ST_BLANK;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    // configuration memory
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= clb_cfg_t'(cfg_word);
    end

    // outputs
    always_comb begin
        cfg     = cfg_q;
        running = (state_q == ST_RUN);
        capture = (state_q == ST_RUN) && !cfg_we;
    end

    a_r2_word_stored: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == clb_cfg_t'($past(cfg_word))));
    a_r3_strobe_to_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (state_q == ST_LOAD));
    a_r3_load_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !cfg_we) |=> (state_q == ST_RUN));
    a_r3_blank_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK && !cfg_we) |=> (state_q == ST_BLANK));
endmodule

// File: rtl/clb_ff_slice.sv
module clb_ff_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cap,
    input  logic run,
    input  logic use_ext,
    input  logic use_reg,
    input  logic lut_d,
    input  logic ext_d,
    output logic y
);
    logic q;
    logic d_sel;

    always_comb begin
        d_sel = use_ext ? ext_d : lut_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= 1'b0;
        else if (cap)      q <= d_sel;
    end

    always_comb begin
        if (!run)         y = 1'b0;
        else if (use_reg) y = q;
        else              y = lut_d;
    end

    a_r10_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == 1'b0));
    a_r8_table_source: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !clr && !use_ext) |=> (q == $past(lut_d)));
    a_r8_direct_source: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !clr && use_ext) |=> (q == $past(ext_d)));
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !clr) |=> $stable(q));
endmodule

// File: rtl/clb_two_stage.sv
module clb_two_stage
    import clb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_word,
    input  logic [FIRST_K-1:0]   f_in,
    input  logic [FIRST_K-1:0]   g_in,
    input  logic                 h_in,
    input  logic                 d_in,
    output logic                 out_a,
    output logic                 out_b
);
    clb_cfg_t          cfg;
    logic              running;
    logic              capture;
    logic              f_out, g_out, h_out;
    logic [N_FF-1:0]   slice_lut_d;
    logic [N_FF-1:0]   slice_src;
    logic [N_FF-1:0]   slice_reg;
    logic [N_FF-1:0]   slice_y;

    clb_cfg_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_word (cfg_word),
        .cfg      (cfg),
        .running  (running),
        .capture  (capture)
    );

    clb_lut #(.K(FIRST_K)) i_lut_f (
        .table_bits (cfg.tab_f),
        .sel        (f_in),
        .y          (f_out)
    );

    clb_lut #(.K(FIRST_K)) i_lut_g (
        .table_bits (cfg.tab_g),
        .sel        (g_in),
        .y          (g_out)
    );

    clb_lut #(.K(SECOND_K)) i_lut_h (
        .table_bits (cfg.tab_h),
        .sel        ({h_in, g_out, f_out}),
        .y          (h_out)
    );

    always_comb begin
        slice_lut_d = {g_out, h_out};
        slice_src   = {cfg.src_b, cfg.src_a};
        slice_reg   = {cfg.reg_b, cfg.reg_a};
    end

    for (genvar i = 0; i < N_FF; i++) begin : g_slice
        clb_ff_slice i_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (cfg_we),
            .cap     (capture),
            .run     (running),
            .use_ext (slice_src[i]),
            .use_reg (slice_reg[i]),
            .lut_d   (slice_lut_d[i]),
            .ext_d   (d_in),
            .y       (slice_y[i])
        );
    end

    always_comb begin
        out_a = slice_y[0];
        out_b = slice_y[1];
    end

    a_r3_quiet_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (out_a == 1'b0 && out_b == 1'b0));
    a_r9_registered_a: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cfg_we && cfg.reg_a && !cfg.src_a) |=> (out_a == $past(h_out)));
    a_r8_registered_b_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cfg_we && cfg.reg_b && cfg.src_b) |=> (out_b == $past(d_in)));
endmodule

// File: tb/test_clb_two_stage.sv
`timescale 1ns/1ps
module test_clb_two_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [43:0] cfg_word = '0;
    logic [3:0]  f_in = '0;
    logic [3:0]  g_in = '0;
    logic        h_in = 1'b0;
    logic        d_in = 1'b0;
    logic        out_a, out_b;

    int checks = 0;
    int failures = 0;

    // model state: 0 blank, 1 load, 2 run
    logic [43:0] mcfg = '0;
    int          mst = 0;
    bit          mqa = 0, mqb = 0;

    always #10 clk = ~clk;

    clb_two_stage i_clb_two_stage (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .f_in(f_in), .g_in(g_in), .h_in(h_in), .d_in(d_in),
        .out_a(out_a), .out_b(out_b)
    );

    function automatic logic [43:0] mk_cfg(logic [15:0] tf, logic [15:0] tg,
                                           logic [7:0] th, bit sa, bit sb, bit ra, bit rb);
        return {tf, tg, th, sa, sb, ra, rb};
    endfunction

    function automatic bit m_f(); return mcfg[28 + f_in]; endfunction
    function automatic bit m_g(); return mcfg[12 + g_in]; endfunction
    function automatic bit m_h(); return mcfg[4 + {h_in, m_g(), m_f()}]; endfunction

    task automatic check(string tag, bit act, bit exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: drive at falling edge, check before rising edge, update model after it
    task automatic cyc(bit we, logic [43:0] w, bit rn, bit rnd, string tag);
        bit ea, eb;
        string ta, tb;
        @(negedge clk);
        rst_n = rn; cfg_we = we; cfg_word = w;
        if (rnd) begin
            f_in = 4'($urandom); g_in = 4'($urandom);
            h_in = 1'($urandom); d_in = 1'($urandom);
        end
        #5;
        if (mst != 2) begin
            ea = 0; eb = 0; ta = "R3"; tb = "R3";
        end else begin
            ea = mcfg[1] ? mqa : m_h();
            eb = mcfg[0] ? mqb : m_g();
            ta = mcfg[1] ? "R9" : "R6";
            tb = mcfg[0] ? "R9" : "R6";
        end
        if (tag != "") begin ta = tag; tb = tag; end
        check(ta, out_a, ea, "out_a");
        check(tb, out_b, eb, "out_b");
        @(posedge clk);
        #1;
        if (!rn) begin
            mcfg = '0; mst = 0; mqa = 0; mqb = 0;
        end else if (we) begin
            mcfg = w; mst = 1; mqa = 0; mqb = 0;
        end else if (mst == 1) begin
            mst = 2;
        end else if (mst == 2) begin
            mqa = mcfg[3] ? d_in : m_h();
            mqb = mcfg[2] ? d_in : m_g();
        end
    endtask

    initial begin
        #4_000_000;
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [43:0] w;
        logic [31:0] tt;
        void'($urandom(32'd1234));

        // R1: reset state
        for (int i = 0; i < 3; i++) cyc(0, '0, 0, 1, "R1");
        for (int i = 0; i < 4; i++) cyc(0, '0, 1, 1, "R1");

        // R2, R4, R6: AND4 on F passed by H, XOR4 on G
        w = mk_cfg(16'h8000, 16'h6996, 8'hAA, 0, 0, 0, 0);
        cyc(1, w, 1, 1, "R3");
        cyc(0, w, 1, 1, "R3");
        for (int i = 0; i < 40; i++) cyc(0, '0, 1, 1, "");
        @(negedge clk); f_in = 4'hF; g_in = 4'h1;
        cyc(0, '0, 1, 0, "R4");
        @(negedge clk); f_in = 4'hE; g_in = 4'h3;
        cyc(0, '0, 1, 0, "R2");

        // R5: arbitrary second-stage table
        w = mk_cfg(16'hA5C3, 16'h0FF0, 8'h96, 0, 0, 0, 0);
        cyc(1, w, 1, 1, "R3");
        cyc(0, w, 1, 1, "R3");
        for (int i = 0; i < 24; i++) cyc(0, '0, 1, 1, "R5");

        // R7: any 5-input function via selector table 8'hCA
        for (int k = 0; k < 4; k++) begin
            tt = $urandom;
            w = mk_cfg(tt[15:0], tt[31:16], 8'hCA, 0, 0, 0, 0);
            cyc(1, w, 1, 1, "R3");
            cyc(0, w, 1, 1, "R3");
            for (int x = 0; x < 32; x++) begin
                @(negedge clk);
                f_in = 4'(x); g_in = 4'(x); h_in = 1'(x >> 4);
                #5;
                check("R7", out_a, tt[x], "out_a five-input");
                cyc(0, '0, 1, 0, "R7");
            end
        end

        // R10, R8, R9: registered outputs, B from direct input
        w = mk_cfg(16'hFFFF, 16'hFFFF, 8'hFF, 0, 1, 1, 1);
        cyc(1, w, 1, 1, "R10");
        cyc(1, w, 1, 1, "R10");
        cyc(0, w, 1, 1, "R10");
        cyc(0, w, 1, 1, "R10");   // first run cycle: flops still clear
        for (int i = 0; i < 30; i++) cyc(0, '0, 1, 1, "R8");
        // reload clears the captured ones
        cyc(1, w, 1, 1, "R10");
        cyc(0, w, 1, 1, "R10");
        cyc(0, w, 1, 1, "R10");

        // random configurations with occasional reloads and resets
        for (int k = 0; k < 30; k++) begin
            w = {$urandom, $urandom}[43:0];
            cyc(1, w, 1, 1, "");
            if (k % 5 == 0) cyc(1, w, 1, 1, "");
            for (int i = 0; i < 60; i++) cyc(0, '0, 1, 1, "");
            if (k % 7 == 3) begin
                cyc(0, '0, 0, 1, "R1");
                cyc(0, '0, 1, 1, "R1");
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule